// File: doc/BRIEF.md
# Descriptor Ring Index Controller

This block keeps the control state of one descriptor ring that lives in host memory. Software sets the ring's base address and entry count through a 32-bit register window. It posts work by moving the head index forward. A hardware agent, typically a DMA engine, reports each finished descriptor with a one-cycle strobe, and the block then moves the tail index forward. Both indices wrap at the ring size. One slot always stays unused, so that a full ring can be told apart from an empty one.

The block guards the ring against bad programming. A head value outside the ring, or one that would overtake the tail, is refused and sets a sticky fault flag. A size that is not a legal power of two is refused and sets a separate sticky flag. Reprogramming the ring geometry, or issuing a ring reset through the control word, returns both indices to zero. The block also drives empty, full and work-pending flags. It pulses a completion output each time the tail moves, so that interrupt-credit logic elsewhere can count finished descriptors.

Top module: `ring_idx_ctrl`

## Requirements
- R1: After reset: base address 0, size 2, head 0, tail 0, credits 0, both fault flags 0, ring_empty 1, ring_full 0, work_pending 0.
- R2: Byte offsets inside the 32-byte window are: 0x00 base low, 0x04 base high, 0x08 size, 0x0C head, 0x10 tail, 0x14 control/status, 0x18 credits. 0x1C reads 0. Reads are combinational from `reg_addr`. A write whose `reg_addr[1:0]` is not 0, or any write to 0x10 or 0x1C, changes nothing.
- R3: The 64-bit base address is written as its low half and then its high half. Bits 2:0 always read 0, so the base is 8-byte aligned.
- R4: A write to either base half, or an accepted size write, sets head and tail to 0 from the next cycle on.
- R5: A size write is accepted only for a power of two from 2 to 2^LOG2_MAX (65536 by default). Any other value leaves size, head and tail unchanged and sets the sticky `size_fault`.
- R6: A head write is accepted only if the value is below the size and (value − tail) mod size ≥ (head − tail) mod size, which means it does not pass tail. A refused write leaves head unchanged and sets the sticky `head_fault`.
- R7: A `hw_done` pulse while head ≠ tail moves tail to (tail+1) mod size, and `desc_done` is high for exactly the following cycle. While head = tail, `hw_done` has no effect and `desc_done` stays 0.
- R8: `ring_empty` = (head = tail). `work_pending` is its inverse. `ring_full` = ((head+1) mod size = tail).
- R9: Writing the control word with bit 0 set clears head, tail, `head_fault` and `size_fault`. A write with bit 0 clear has no effect. The control word reads back `head_fault` in bit 0 and `size_fault` in bit 1.
- R10: The credits word is a plain 32-bit read/write register.
- R11: Head and tail both wrap from size−1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset within the ring window, used for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| hw_done | input | 1 | Hardware finished the descriptor at tail |
| desc_done | output | 1 | One-cycle pulse: tail advanced |
| ring_empty | output | 1 | Head equals tail |
| ring_full | output | 1 | Head is one slot behind tail |
| work_pending | output | 1 | Descriptors posted but not completed |
| head_fault | output | 1 | Sticky: a head write was refused |
| size_fault | output | 1 | Sticky: a size write was refused |

## Verification
Every register write takes effect at the clock edge that samples it. Its result shows on `reg_rdata` and on the flags from the following cycle, while a read returns data in the same cycle as its address. The tail moves at the edge that samples `hw_done`, and `desc_done` is high during the next cycle only. The bench therefore drives inputs at the falling edge and checks at the next falling edge, one edge after the stimulus. In that cycle it also confirms that `desc_done` has dropped.

// File: rtl/ring_idx_pkg.sv
// Shared definitions for the descriptor ring index controller.
// Assumes a 32-byte register window of eight 32-bit words.
package ring_idx_pkg;
    typedef enum logic [2:0] {
        W_BASE_LO = 3'd0,
        W_BASE_HI = 3'd1,
        W_SIZE    = 3'd2,
        W_HEAD    = 3'd3,
        W_TAIL    = 3'd4,
        W_CTRL    = 3'd5,
        W_CREDIT  = 3'd6,
        W_SPARE   = 3'd7
    } ring_word_e;

    localparam int CTRL_RST_BIT = 0;
endpackage

// File: rtl/ring_cfg_regs.sv
// Configuration registers: base address, size, credits and the size fault.
// Assumes wr_en is already qualified for word alignment. Generates the
// index-clear request when the ring geometry changes or a ring reset is written.
module ring_cfg_regs
    import ring_idx_pkg::*;
#(
    parameter int LOG2_MAX = 16,
    localparam int SZ_W = LOG2_MAX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  ring_word_e       wr_word,
    input  logic [31:0]      wr_data,
    output logic [63:0]      base_q,
    output logic [SZ_W-1:0]  size_q,
    output logic [31:0]      credit_q,
    output logic             size_fault,
    output logic             ctrl_rst,
    output logic             clr_idx
);
    logic size_ok;
    logic size_wr;

    // Legal size: power of two, at least 2, no bits above the largest size
    always_comb begin
        size_ok = (wr_data[31:SZ_W] == '0) &&
                  ($countones(wr_data[SZ_W-1:0]) == 1) &&
                  !wr_data[0];
    end

    // Decode writes that reset the ring indices
    always_comb begin
        size_wr  = wr_en && (wr_word == W_SIZE);
        ctrl_rst = wr_en && (wr_word == W_CTRL) && wr_data[CTRL_RST_BIT];
        clr_idx  = (wr_en && ((wr_word == W_BASE_LO) || (wr_word == W_BASE_HI))) ||
                   (size_wr && size_ok) || ctrl_rst;
    end

    // Base address halves; the three low bits are forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en && wr_word == W_BASE_LO) begin
            base_q[31:0] <= {wr_data[31:3], 3'b000};
        end else if (wr_en && wr_word == W_BASE_HI) begin
            base_q[63:32] <= wr_data;
        end
    end

    // Ring size register, updated only by a legal value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_W'(2);
        end else if (size_wr && size_ok) begin
            size_q <= wr_data[SZ_W-1:0];
        end
    end

    // Sticky size fault: set by a refused size, cleared by a ring reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_fault <= 1'b0;
        end else if (ctrl_rst) begin
            size_fault <= 1'b0;
        end else if (size_wr && !size_ok) begin
            size_fault <= 1'b1;
        end
    end

    // Credits word is plain storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else if (wr_en && wr_word == W_CREDIT) begin
            credit_q <= wr_data;
        end
    end

    AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(size_q) == 1) && !size_q[0]);  // R5
    AST_BAD_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && !size_ok) |=> (size_q == $past(size_q)) && size_fault);  // R5
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[2:0] == 3'b000);  // R3
endmodule

// File: rtl/ring_idx_track.sv
// Head and tail index tracking for one ring.
// Assumes mask = size-1 for a power-of-two size. Checks head writes against
// the ring bounds and the tail, advances tail on completions and keeps the head fault.
module ring_idx_track #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] mask,
    input  logic             clr,
    input  logic             fault_clr,
    input  logic             head_wr,
    input  logic [31:0]      head_val,
    input  logic             hw_done,
    output logic [IDX_W-1:0] head_q,
    output logic [IDX_W-1:0] tail_q,
    output logic             desc_done,
    output logic             head_fault,
    output logic             empty,
    output logic             full
);
    logic [IDX_W-1:0] new_head;
    logic [IDX_W-1:0] dist_old;
    logic [IDX_W-1:0] dist_new;
    logic             in_ring;
    logic             head_ok;
    logic             advance;

    // Judge a head write: inside the ring and not overtaking tail
    always_comb begin
        new_head = head_val[IDX_W-1:0];
        in_ring  = (head_val[31:IDX_W] == '0) && ((new_head & ~mask) == '0);
        dist_old = (head_q - tail_q) & mask;
        dist_new = (new_head - tail_q) & mask;
        head_ok  = in_ring && (dist_new >= dist_old);
    end

    // Ring state flags
    always_comb begin
        empty   = (head_q == tail_q);
        full    = (((head_q + 1'b1) & mask) == tail_q);
        advance = hw_done && !empty && !clr;
    end

    // Head index, written only by software
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head_q <= '0;
        end else if (head_wr && head_ok) begin
            head_q <= new_head;
        end
    end

    // Tail index, moved by hardware completions
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tail_q <= '0;
        end else if (advance) begin
            tail_q <= (tail_q + 1'b1) & mask;
        end
    end

    // Completion pulse for the credit logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_done <= 1'b0;
        end else begin
            desc_done <= advance;
        end
    end

    // Sticky fault for a refused head write
    always_ff @(posedge clk) begin
        if (!rst_n || fault_clr) begin
            head_fault <= 1'b0;
        end else if (head_wr && !head_ok) begin
            head_fault <= 1'b1;
        end
    end

    AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q & ~mask) == '0);  // R6
    AST_REFUSED_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (head_wr && !head_ok && !clr) |=> (head_q == $past(head_q)) && head_fault);  // R6
    AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |-> (tail_q == ((IDX_W'($past(tail_q)) + 1'b1) & mask)));  // R7
    AST_NO_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_done && empty) |=> !desc_done);  // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (head_q == '0) && (tail_q == '0));  // R4
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));  // R8
endmodule

// File: rtl/ring_idx_ctrl.sv
// Top of the descriptor ring index controller.
// Assumes one register access per cycle at a byte offset in a 32-byte window;
// writes must be word aligned. Reads are combinational.
module ring_idx_ctrl
    import ring_idx_pkg::*;
#(
    parameter int LOG2_MAX = 16,
    localparam int SZ_W  = LOG2_MAX + 1,
    localparam int IDX_W = LOG2_MAX
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hw_done,
    output logic        desc_done,
    output logic        ring_empty,
    output logic        ring_full,
    output logic        work_pending,
    output logic        head_fault,
    output logic        size_fault
);
    ring_word_e       word;
    logic             aligned;
    logic             wr_ok;
    logic [63:0]      base_q;
    logic [SZ_W-1:0]  size_q;
    logic [31:0]      credit_q;
    logic             ctrl_rst;
    logic             clr_idx;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;

    // Address decode and write qualification
    always_comb begin
        word    = ring_word_e'(reg_addr[4:2]);
        aligned = (reg_addr[1:0] == 2'b00);
        wr_ok   = reg_wr && aligned;
        mask    = IDX_W'(size_q - 1'b1);
    end

    ring_cfg_regs #(.LOG2_MAX(LOG2_MAX)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok),
        .wr_word    (word),
        .wr_data    (reg_wdata),
        .base_q     (base_q),
        .size_q     (size_q),
        .credit_q   (credit_q),
        .size_fault (size_fault),
        .ctrl_rst   (ctrl_rst),
        .clr_idx    (clr_idx)
    );

    ring_idx_track #(.IDX_W(IDX_W)) u_idx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask       (mask),
        .clr        (clr_idx),
        .fault_clr  (ctrl_rst),
        .head_wr    (wr_ok && (word == W_HEAD)),
        .head_val   (reg_wdata),
        .hw_done    (hw_done),
        .head_q     (head_q),
        .tail_q     (tail_q),
        .desc_done  (desc_done),
        .head_fault (head_fault),
        .empty      (ring_empty),
        .full       (ring_full)
    );

    // Pending work mirrors a non-empty ring
    always_comb begin
        work_pending = !ring_empty;
    end

    // Read data mux
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (word)
                W_BASE_LO: reg_rdata = base_q[31:0];
                W_BASE_HI: reg_rdata = base_q[63:32];
                W_SIZE:    reg_rdata = 32'(size_q);
                W_HEAD:    reg_rdata = 32'(head_q);
                W_TAIL:    reg_rdata = 32'(tail_q);
                W_CTRL:    reg_rdata = {30'd0, size_fault, head_fault};
                W_CREDIT:  reg_rdata = credit_q;
                default:   reg_rdata = '0;
            endcase
        end
    end

    AST_TAIL_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q & ~mask) == '0);  // R11
    AST_PENDING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        work_pending |-> (reg_addr != 5'h10 || reg_rdata != 32'(head_q)));  // R8
endmodule

// File: tb/ring_idx_ctrl_bench.sv
`timescale 1ns/1ps
module ring_idx_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_done = 1'b0;
    logic        desc_done, ring_empty, ring_full, work_pending, head_fault, size_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ring_idx_ctrl u_ring_idx_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_done(hw_done),
        .desc_done(desc_done), .ring_empty(ring_empty), .ring_full(ring_full),
        .work_pending(work_pending), .head_fault(head_fault), .size_fault(size_fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One completion strobe; desc_done checked the cycle after, gone one later
    task automatic done_pulse(input logic exp_done, input string req);
        @(negedge clk);
        hw_done = 1'b1;
        @(negedge clk);
        hw_done = 1'b0;
        chk(req, desc_done, exp_done);
        @(negedge clk);
        chk(req, desc_done, 1'b0);
    endtask

    task automatic idx_chk(input logic [31:0] h, input logic [31:0] t, input string req);
        logic [31:0] v;
        rd(5'h0C, v); chk(req, v, h);
        rd(5'h10, v); chk(req, v, t);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); chk("R1 base lo", v, 0);
        rd(5'h04, v); chk("R1 base hi", v, 0);
        rd(5'h08, v); chk("R1 size", v, 2);
        rd(5'h18, v); chk("R1 credits", v, 0);
        rd(5'h14, v); chk("R1 faults", v, 0);
        idx_chk(0, 0, "R1 indices");
        chk("R1 flags", {ring_empty, ring_full, work_pending, desc_done}, 4'b1000);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(5'h18, 32'hCAFE_1234);
        rd(5'h18, v); chk("R10 credits", v, 32'hCAFE_1234);
        wr(5'h1A, 32'h0000_0001);
        rd(5'h18, v); chk("R2 unaligned write ignored", v, 32'hCAFE_1234);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h1C, v); chk("R2 spare word", v, 0);
        wr(5'h10, 32'h1);
        rd(5'h10, v); chk("R2 tail read-only", v, 0);
        wr(5'h00, 32'h1234_567F);
        wr(5'h04, 32'h0000_00AB);
        rd(5'h00, v); chk("R3 base lo aligned", v, 32'h1234_5678);
        rd(5'h04, v); chk("R3 base hi", v, 32'h0000_00AB);
    endtask

    task automatic t_size;
        logic [31:0] v;
        wr(5'h08, 8);
        rd(5'h08, v); chk("R5 size 8", v, 8);
        wr(5'h0C, 3);
        wr(5'h08, 12);
        rd(5'h08, v); chk("R5 size 12 refused", v, 8);
        idx_chk(3, 0, "R5 indices kept");
        chk("R5 size_fault", size_fault, 1'b1);
        rd(5'h14, v); chk("R9 status bit1", v, 2);
        wr(5'h08, 1);
        rd(5'h08, v); chk("R5 size 1 refused", v, 8);
        wr(5'h08, 32'h0002_0000);
        rd(5'h08, v); chk("R5 size 131072 refused", v, 8);
        wr(5'h08, 32'h0001_0000);
        rd(5'h08, v); chk("R5 size 65536", v, 32'h0001_0000);
        idx_chk(0, 0, "R4 size write clears");
        wr(5'h08, 8);
    endtask

    task automatic t_flow;
        logic [31:0] v;
        wr(5'h0C, 5);
        idx_chk(5, 0, "R6 head accepted");
        chk("R8 pending", {ring_empty, ring_full, work_pending}, 3'b001);
        for (int i = 0; i < 5; i++) done_pulse(1'b1, "R7 desc_done");
        idx_chk(5, 5, "R7 tail caught up");
        chk("R8 empty", ring_empty, 1'b1);
        done_pulse(1'b0, "R7 done ignored when empty");
        idx_chk(5, 5, "R7 tail held");
        wr(5'h0C, 2);
        idx_chk(2, 5, "R11 head wraps");
        for (int i = 0; i < 5; i++) done_pulse(1'b1, "R11 tail advance");
        idx_chk(2, 2, "R11 tail wraps");
        wr(5'h0C, 1);
        chk("R8 full", {ring_empty, ring_full, work_pending}, 3'b011);
        chk("R6 no fault yet", head_fault, 1'b0);
        wr(5'h0C, 2);
        idx_chk(1, 2, "R6 pass tail refused");
        chk("R6 head_fault", head_fault, 1'b1);
        rd(5'h14, v); chk("R9 status bits", v, 3);
        wr(5'h0C, 9);
        idx_chk(1, 2, "R6 out of ring refused");
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        wr(5'h14, 32'hFFFF_FFFE);
        idx_chk(1, 2, "R9 bit0 clear no effect");
        chk("R9 faults kept", {head_fault, size_fault}, 2'b11);
        wr(5'h14, 1);
        idx_chk(0, 0, "R9 ring reset");
        chk("R9 faults cleared", {head_fault, size_fault}, 2'b00);
        wr(5'h0C, 4);
        done_pulse(1'b1, "R7 before base write");
        wr(5'h04, 32'h77);
        idx_chk(0, 0, "R4 base write clears");
        rd(5'h08, v); chk("R4 size kept", v, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_size();
        t_flow();
        t_ctrl();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule